// File: doc/BRIEF.md
# Cascadable Four-Mode Binary Counter Stage

This block is a synchronous binary counter slice, four bits wide by default. Two select lines pick one of four behaviours on each rising clock edge: parallel load from a data bus, count up, count down, or freeze. An active-low enable input, the carry-in, gates both counting modes. It has no effect on load or on freeze.

The active-low carry-out is combinational, so stages can be chained. It falls when the stage is counting with its carry-in asserted and the count sits at the terminal value for the current direction. It also falls whenever load is selected. Several stages share one clock, and each stage's carry-out feeds the next stage's carry-in. The stages then count together as one wider counter, and only the first stage in the chain is enabled by a constant. A synchronous active-high reset clears the count.

Top module: `updown_stage`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q` becomes all zeros on that edge, whatever `sel`, `cin_n` and `din` are.
- R2: With `sel` = 2'b00 (load), `q` takes the value of `din` on the next rising edge, for either level of `cin_n`.
- R3: With `sel` = 2'b01 (up) and `cin_n` low, `q` increases by one on each rising edge, and all ones wraps to all zeros.
- R4: With `sel` = 2'b10 (down) and `cin_n` low, `q` decreases by one on each rising edge, and all zeros wraps to all ones.
- R5: With `sel` = 2'b01 or 2'b10 and `cin_n` high, `q` keeps its value across the edge.
- R6: With `sel` = 2'b11 (freeze), `q` keeps its value and `cout_n` stays high, for either level of `cin_n`.
- R7: `cout_n` is low whenever `sel` = 2'b00, whatever the count and `cin_n`.
- R8: In up mode, `cout_n` is low exactly when `cin_n` is low and `q` is all ones. In down mode, it is low exactly when `cin_n` is low and `q` is all zeros. Otherwise it is high. It follows its inputs within the same cycle.
- R9: Two stages on one clock, with the lower stage's `cout_n` wired to the upper stage's `cin_n` and the lower `cin_n` held low, count as one 8-bit counter in both directions, including the 8-bit wrap. The upper `cout_n` marks the 8-bit terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; every state change happens on it |
| rst | input | 1 | Synchronous active-high reset, clears the count |
| sel | input | 2 | Mode select: 00 load, 01 up, 10 down, 11 freeze |
| cin_n | input | 1 | Active-low count enable / carry input |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Registered count |
| cout_n | output | 1 | Active-low combinational carry output |

## Verification
Two functions can land on the same edge: the terminal-count carry of the lower stage, and the wraparound of that stage. On that edge the upper stage steps while the lower stage rolls over. The bench provokes this by loading the chained pair just below 8'hFF in up mode and just above 8'h00 in down mode, then stepping across the boundary. It checks the upper carry-out before each edge and the combined 8-bit value after it. In the single-stage case, an exhaustive sweep covers every start value under every select and carry-in combination. That sweep confirms that the carry falls in the cycle before each wrap and that the wrap lands on the expected value.

// File: rtl/updown_pkg.sv
package updown_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD   = 2'b00,
    MODE_UP     = 2'b01,
    MODE_DOWN   = 2'b10,
    MODE_FREEZE = 2'b11
  } mode_e;
endpackage

// File: rtl/ud_mode_decode.sv
module ud_mode_decode
  import updown_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       cin_n,
  output logic       do_load,
  output logic       do_inc,
  output logic       do_dec
);
  mode_e mode;

  always_comb begin
    mode    = mode_e'(sel);
    do_load = (mode == MODE_LOAD);
    do_inc  = (mode == MODE_UP)   && !cin_n;
    do_dec  = (mode == MODE_DOWN) && !cin_n;
  end
endmodule

// File: rtl/ud_next_count.sv
module ud_next_count #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  logic             do_load,
  input  logic             do_inc,
  input  logic             do_dec,
  output logic [WIDTH-1:0] q_nxt
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    if (do_load)     q_nxt = din;
    else if (do_inc) q_nxt = q + ONE;
    else if (do_dec) q_nxt = q - ONE;
    else             q_nxt = q;
  end
endmodule

// File: rtl/ud_carry_gen.sv
module ud_carry_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             do_load,
  input  logic             do_inc,
  input  logic             do_dec,
  output logic             cout_n
);
  logic at_top, at_bottom;

  always_comb begin
    at_top    = &q;
    at_bottom = ~|q;
    cout_n    = !(do_load || (do_inc && at_top) || (do_dec && at_bottom));
  end
endmodule

// File: rtl/updown_stage.sv
module updown_stage
  import updown_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel,
  input  logic             cin_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             cout_n
);
  logic             do_load, do_inc, do_dec;
  logic [WIDTH-1:0] q_nxt;

  ud_mode_decode u_decode (
    .sel     (sel),
    .cin_n   (cin_n),
    .do_load (do_load),
    .do_inc  (do_inc),
    .do_dec  (do_dec)
  );

  ud_next_count #(.WIDTH(WIDTH)) u_next (
    .q       (q),
    .din     (din),
    .do_load (do_load),
    .do_inc  (do_inc),
    .do_dec  (do_dec),
    .q_nxt   (q_nxt)
  );

  ud_carry_gen #(.WIDTH(WIDTH)) u_carry (
    .q       (q),
    .do_load (do_load),
    .do_inc  (do_inc),
    .do_dec  (do_dec),
    .cout_n  (cout_n)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_LOAD) |=> (q == $past(din)));

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_UP && !cin_n) |=> (q == $past(q) + 1'b1));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_DOWN && !cin_n) |=> (q == $past(q) - 1'b1));

  // R5
  gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((sel == MODE_UP || sel == MODE_DOWN) && cin_n) |=> $stable(q));

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_FREEZE) |=> $stable(q));

  // R6
  freeze_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_FREEZE) |-> cout_n);

  // R7
  load_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_LOAD) |-> !cout_n);

  // R8
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_UP && !cout_n) |=> (q == '0));

  // R8
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_DOWN && !cout_n) |=> (q == '1));
endmodule

// File: tb/test_updown_stage.sv
module test_updown_stage;
  localparam int W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst;
  logic [1:0]   sel;
  logic         cin_n;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         cout_n;

  logic [W-1:0] lo_din, hi_din, lo_q, hi_q;
  logic         lo_cout_n, hi_cout_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  updown_stage #(.WIDTH(W)) i_updown_stage (
    .clk(clk), .rst(rst), .sel(sel), .cin_n(cin_n), .din(din),
    .q(q), .cout_n(cout_n)
  );

  updown_stage #(.WIDTH(W)) i_lo_stage (
    .clk(clk), .rst(rst), .sel(sel), .cin_n(1'b0), .din(lo_din),
    .q(lo_q), .cout_n(lo_cout_n)
  );

  updown_stage #(.WIDTH(W)) i_hi_stage (
    .clk(clk), .rst(rst), .sel(sel), .cin_n(lo_cout_n), .din(hi_din),
    .q(hi_q), .cout_n(hi_cout_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel = 2'b00; cin_n = 1'b0; din = 4'd9;
    lo_din = 4'd7; hi_din = 4'd3;
    step(); step();
    // R1: reset wins over a pending load
    chk("R1 single q", int'(q), 0);
    chk("R1 cascade", int'({hi_q, lo_q}), 0);
    rst = 1'b0;

    // Exhaustive sweep: every start value, select and carry-in
    for (int v = 0; v < 16; v++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 2; c++) begin
          int exp_q;
          int exp_c;
          sel = 2'b00; din = W'(v); cin_n = 1'(c ^ 1);
          step();
          chk("R2 load", int'(q), v);
          sel = 2'(s); cin_n = 1'(c); din = W'(15 - v);
          #1;
          case (s)
            0: exp_c = 0;
            1: exp_c = (c == 0 && v == 15) ? 0 : 1;
            2: exp_c = (c == 0 && v == 0) ? 0 : 1;
            default: exp_c = 1;
          endcase
          if (s == 0)      chk("R7 load carry", int'(cout_n), exp_c);
          else if (s == 3) chk("R6 freeze carry", int'(cout_n), exp_c);
          else             chk("R8 count carry", int'(cout_n), exp_c);
          step();
          if (s == 0)                exp_q = 15 - v;
          else if (s == 1 && c == 0) exp_q = (v + 1) % 16;
          else if (s == 2 && c == 0) exp_q = (v + 15) % 16;
          else                       exp_q = v;
          case (s)
            0: chk("R2 load any cin", int'(q), exp_q);
            1: chk(c == 0 ? "R3 up" : "R5 up gated", int'(q), exp_q);
            2: chk(c == 0 ? "R4 down" : "R5 down gated", int'(q), exp_q);
            default: chk("R6 freeze", int'(q), exp_q);
          endcase
        end
      end
    end

    // R9: cascade up across the 8-bit wrap
    begin
      int e = 250;
      sel = 2'b00; lo_din = W'(e % 16); hi_din = W'(e / 16);
      step();
      chk("R9 cascade load", int'({hi_q, lo_q}), e);
      sel = 2'b01;
      for (int i = 0; i < 40; i++) begin
        #1;
        chk("R9 cascade up carry", int'(hi_cout_n), (e == 255) ? 0 : 1);
        step();
        e = (e + 1) % 256;
        chk("R9 cascade up", int'({hi_q, lo_q}), e);
      end

      // R9: cascade down across the 8-bit wrap
      e = 20;
      sel = 2'b00; lo_din = W'(e % 16); hi_din = W'(e / 16);
      step();
      sel = 2'b10;
      for (int i = 0; i < 40; i++) begin
        #1;
        chk("R9 cascade down carry", int'(hi_cout_n), (e == 0) ? 0 : 1);
        step();
        e = (e + 255) % 256;
        chk("R9 cascade down", int'({hi_q, lo_q}), e);
      end
    end

    // R1: reset in mid-count
    sel = 2'b01; rst = 1'b1;
    step();
    chk("R1 reset mid-count", int'({hi_q, lo_q}), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule